// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block is the top-level state machine of a two-phase step-down converter controller that decides whether the power stage may switch. It takes already digitized comparator flags and converts them into three commands for the phase logic. The flags cover supply lockout with separate start and hold thresholds, feedback overvoltage, die overtemperature with a separate release threshold and the enable pin. The phase logic also reports an overcurrent trip and the return of the inductor current to zero. The commands are a gate enable, a forced low-side command (low-side switch on, high-side switch off), and a soft-start reference scale that ramps from zero to full.

Every start goes through a soft-start ramp, and so does every restart after an overcurrent. The scale rises by a programmable step on each slow tick strobe. Overvoltage is latched and is released only by a supply power cycle through lockout. A thermal shutdown returns through soft-start once the die has cooled. Dropping the enable returns the block to idle and blocks power-good.

Top module: `pss_supervisor`

## Requirements
- R1: During and right after reset the block is idle: gate enable 0, forced low-side 0, scale 0, power-good enable 0.
- R2: Lockout asserts when `vcc_hold_ok` is low and releases only once `vcc_start_ok` is high. `vcc_hold_ok` high with `vcc_start_ok` low keeps the current lockout state. While locked the gates stay off, and two cycles after `vcc_hold_ok` falls the gate enable is 0.
- R3: One cycle after `ov_i` is seen high, from any state, forced low-side is 1, gate enable is 0 and scale is 0.
- R4: The overvoltage latch persists after `ov_i` falls, whatever the enable, thermal or overcurrent inputs do. It clears only when lockout is asserted with `ov_i` low, and the next start then goes through soft-start.
- R5: One cycle after `hot_trip_i` is seen high, gate enable is 0. The block stays off until `hot_clear_i` is high with `hot_trip_i` low, then goes idle and restarts through soft-start.
- R6: One cycle after `en_i` is seen low, gate enable and power-good enable are 0.
- R7: Soft-start starts with the scale at 0 and adds `ss_step_i` on each cycle with `tick_i` high. A step of 0 counts as 1. The scale saturates at 2^SCALE_W-1. Gates are off while the soft-start scale is 0 and on otherwise.
- R8: The cycle after the scale reaches full, the block runs. In run, the scale is full, the gates are on and power-good enable is 1.
- R9: `oc_trip_i` during soft-start or run puts the block into overcurrent recovery on the next cycle, with forced low-side 1 and gates off. `oc_zero_i` then restarts soft-start from scale 0.
- R10: When several conditions coincide, the priority is overvoltage, then lockout, then thermal, then enable, then overcurrent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_start_ok | input | 1 | Supply above the rising lockout threshold |
| vcc_hold_ok | input | 1 | Supply above the falling lockout threshold |
| ov_i | input | 1 | Feedback above the overvoltage threshold |
| hot_trip_i | input | 1 | Die above the shutdown temperature |
| hot_clear_i | input | 1 | Die below the release temperature |
| en_i | input | 1 | Enable pin, active high |
| oc_trip_i | input | 1 | Overcurrent trip from the phase logic |
| oc_zero_i | input | 1 | Inductor current back to zero (restart request) |
| tick_i | input | 1 | Soft-start time-base strobe |
| ss_step_i | input | SCALE_W | Scale increment per tick |
| gate_en_o | output | 1 | Switching permitted |
| force_low_o | output | 1 | Low-side on, high-side off |
| ss_scale_o | output | SCALE_W | Soft-start reference scale |
| pgood_en_o | output | 1 | Power-good may assert |

## Verification
Overvoltage and lockout can land in the same cycle as a thermal trip, a falling enable and an overcurrent report. The directed part drives all of them together from run and checks that only the latch's forced low-side command appears. It then checks that lockout, and not the still-high thermal flag, takes over once the overvoltage flag drops. An overcurrent trip can also fall in the same cycle as the ramp reaching full. The random phase produces that case with frequent ticks and trips, and a cycle-accurate bench model judges every cycle.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_SOFT    = 3'd1,
        ST_RUN     = 3'd2,
        ST_OCREC   = 3'd3,
        ST_HOT     = 3'd4,
        ST_OVLATCH = 3'd5
    } sup_state_e;

    typedef struct packed {
        logic ov;
        logic lock;
        logic hot_trip;
        logic hot_clear;
        logic en;
        logic oc_trip;
        logic oc_zero;
    } sup_flags_t;

    // Priority order: overvoltage, lockout, thermal, enable, overcurrent (R10)
    function automatic sup_state_e next_state(sup_state_e s, sup_flags_t f, logic full);
        sup_state_e n;
        n = s;
        if (f.ov)                     n = ST_OVLATCH;
        else if (s == ST_OVLATCH)     n = f.lock ? ST_OFF : ST_OVLATCH;
        else if (f.lock)              n = ST_OFF;
        else if (s == ST_HOT)         n = (f.hot_clear && !f.hot_trip) ? ST_OFF : ST_HOT;
        else if (f.hot_trip)          n = ST_HOT;
        else if (!f.en)               n = ST_OFF;
        else begin
            case (s)
                ST_OFF:   n = ST_SOFT;
                ST_SOFT:  n = f.oc_trip ? ST_OCREC : (full ? ST_RUN : ST_SOFT);
                ST_RUN:   n = f.oc_trip ? ST_OCREC : ST_RUN;
                ST_OCREC: n = f.oc_zero ? ST_SOFT : ST_OCREC;
                default:  n = ST_OFF;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/pss_lockout.sv
module pss_lockout #(
    parameter logic RESET_LOCKED = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic above_start,
    input  logic above_hold,
    output logic locked
);
    always_ff @(posedge clk) begin
        if (rst)         locked <= RESET_LOCKED;
        else if (locked) locked <= !above_start;
        else             locked <= !above_hold;
    end
endmodule

// File: rtl/pss_ramp.sv
module pss_ramp #(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               advance,
    input  logic [SCALE_W-1:0] step,
    output logic [SCALE_W-1:0] scale,
    output logic               full
);
    localparam logic [SCALE_W-1:0] FULL_SCALE = {SCALE_W{1'b1}};

    logic [SCALE_W-1:0] eff_step;
    logic [SCALE_W:0]   sum;

    always_comb begin
        eff_step = (step == '0) ? {{(SCALE_W-1){1'b0}}, 1'b1} : step;
        sum      = {1'b0, scale} + {1'b0, eff_step};
    end

    always_ff @(posedge clk) begin
        if (rst || clear)  scale <= '0;
        else if (advance)  scale <= sum[SCALE_W] ? FULL_SCALE : sum[SCALE_W-1:0];
    end

    assign full = (scale == FULL_SCALE);
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
    import pss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sup_flags_t flags,
    input  logic       ramp_full,
    output sup_state_e state
);
    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= next_state(state, flags, ramp_full);
    end
endmodule

// File: rtl/pss_supervisor.sv
module pss_supervisor
    import pss_pkg::*;
#(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vcc_start_ok,
    input  logic               vcc_hold_ok,
    input  logic               ov_i,
    input  logic               hot_trip_i,
    input  logic               hot_clear_i,
    input  logic               en_i,
    input  logic               oc_trip_i,
    input  logic               oc_zero_i,
    input  logic               tick_i,
    input  logic [SCALE_W-1:0] ss_step_i,
    output logic               gate_en_o,
    output logic               force_low_o,
    output logic [SCALE_W-1:0] ss_scale_o,
    output logic               pgood_en_o
);
    localparam logic [SCALE_W-1:0] FULL_SCALE = {SCALE_W{1'b1}};

    logic               locked;
    logic [SCALE_W-1:0] ramp;
    logic               ramp_full;
    sup_flags_t         flags;
    sup_state_e         state;

    pss_lockout #(.RESET_LOCKED(1'b1)) u_lock (
        .clk(clk), .rst(rst),
        .above_start(vcc_start_ok), .above_hold(vcc_hold_ok),
        .locked(locked)
    );

    always_comb begin
        flags.ov        = ov_i;
        flags.lock      = locked;
        flags.hot_trip  = hot_trip_i;
        flags.hot_clear = hot_clear_i;
        flags.en        = en_i;
        flags.oc_trip   = oc_trip_i;
        flags.oc_zero   = oc_zero_i;
    end

    pss_fsm u_fsm (
        .clk(clk), .rst(rst), .flags(flags),
        .ramp_full(ramp_full), .state(state)
    );

    pss_ramp #(.SCALE_W(SCALE_W)) u_ramp (
        .clk(clk), .rst(rst),
        .clear(state != ST_SOFT),
        .advance(tick_i && state == ST_SOFT),
        .step(ss_step_i),
        .scale(ramp), .full(ramp_full)
    );

    always_comb begin
        gate_en_o   = (state == ST_RUN) || (state == ST_SOFT && ramp != '0);
        force_low_o = (state == ST_OVLATCH) || (state == ST_OCREC);
        pgood_en_o  = (state == ST_RUN);
        case (state)
            ST_RUN:  ss_scale_o = FULL_SCALE;
            ST_SOFT: ss_scale_o = ramp;
            default: ss_scale_o = '0;
        endcase
    end
endmodule

// File: rtl/pss_supervisor_chk.sv
module pss_supervisor_chk #(
    parameter int SCALE_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               vcc_hold_ok,
    input logic               ov_i,
    input logic               hot_trip_i,
    input logic               en_i,
    input logic               gate_en_o,
    input logic               force_low_o,
    input logic [SCALE_W-1:0] ss_scale_o,
    input logic               pgood_en_o
);
    localparam logic [SCALE_W-1:0] FULL_SCALE = {SCALE_W{1'b1}};

    p_no_shoot_r9: assert property (@(posedge clk) disable iff (rst)
        !(gate_en_o && force_low_o));

    p_ov_force_r3: assert property (@(posedge clk) disable iff (rst)
        ov_i |=> (force_low_o && !gate_en_o && ss_scale_o == '0));

    p_lockout_off_r2: assert property (@(posedge clk) disable iff (rst)
        !vcc_hold_ok |=> ##1 !gate_en_o);

    p_hot_off_r5: assert property (@(posedge clk) disable iff (rst)
        hot_trip_i |=> !gate_en_o);

    p_enable_low_r6: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!gate_en_o && !pgood_en_o));

    p_run_full_r8: assert property (@(posedge clk) disable iff (rst)
        pgood_en_o |-> (ss_scale_o == FULL_SCALE && gate_en_o));
endmodule

bind pss_supervisor pss_supervisor_chk #(.SCALE_W(SCALE_W)) u_chk (
    .clk(clk), .rst(rst), .vcc_hold_ok(vcc_hold_ok), .ov_i(ov_i),
    .hot_trip_i(hot_trip_i), .en_i(en_i), .gate_en_o(gate_en_o),
    .force_low_o(force_low_o), .ss_scale_o(ss_scale_o), .pgood_en_o(pgood_en_o)
);

// File: tb/sim_pss_supervisor.sv
module sim_pss_supervisor;
    localparam int SW = 8;
    localparam logic [SW-1:0] FULL = {SW{1'b1}};

    // bench-side state codes
    localparam int M_OFF = 0, M_SOFT = 1, M_RUN = 2, M_OCR = 3, M_HOT = 4, M_OVL = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vcc_start_ok = 1'b1, vcc_hold_ok = 1'b1, ov_i = 1'b0;
    logic hot_trip_i = 1'b0, hot_clear_i = 1'b1, en_i = 1'b1;
    logic oc_trip_i = 1'b0, oc_zero_i = 1'b0, tick_i = 1'b0;
    logic [SW-1:0] ss_step_i = 8'd64;
    logic gate_en_o, force_low_o, pgood_en_o;
    logic [SW-1:0] ss_scale_o;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int m_state = M_OFF;
    bit m_lock = 1'b1;
    logic [SW-1:0] m_scale = '0;

    always #4 clk = ~clk;

    pss_supervisor #(.SCALE_W(SW)) u0 (
        .clk(clk), .rst(rst), .vcc_start_ok(vcc_start_ok), .vcc_hold_ok(vcc_hold_ok),
        .ov_i(ov_i), .hot_trip_i(hot_trip_i), .hot_clear_i(hot_clear_i), .en_i(en_i),
        .oc_trip_i(oc_trip_i), .oc_zero_i(oc_zero_i), .tick_i(tick_i),
        .ss_step_i(ss_step_i), .gate_en_o(gate_en_o), .force_low_o(force_low_o),
        .ss_scale_o(ss_scale_o), .pgood_en_o(pgood_en_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_next(int s, bit lk, logic [SW-1:0] sc);
        if (ov_i) return M_OVL;
        if (s == M_OVL) return lk ? M_OFF : M_OVL;
        if (lk) return M_OFF;
        if (s == M_HOT) return (hot_clear_i && !hot_trip_i) ? M_OFF : M_HOT;
        if (hot_trip_i) return M_HOT;
        if (!en_i) return M_OFF;
        case (s)
            M_OFF:  return M_SOFT;
            M_SOFT: return oc_trip_i ? M_OCR : (sc == FULL ? M_RUN : M_SOFT);
            M_RUN:  return oc_trip_i ? M_OCR : M_RUN;
            M_OCR:  return oc_zero_i ? M_SOFT : M_OCR;
            default: return M_OFF;
        endcase
    endfunction

    function automatic logic [SW-1:0] model_scale(int s, logic [SW-1:0] sc);
        int st, sum;
        if (s != M_SOFT) return '0;
        if (!tick_i) return sc;
        st = (ss_step_i == 0) ? 1 : int'(ss_step_i);
        sum = int'(sc) + st;
        return (sum > int'(FULL)) ? FULL : sum[SW-1:0];
    endfunction

    function automatic string tag_of(int s);
        case (s)
            M_SOFT: return "R7";
            M_RUN:  return "R8";
            M_OCR:  return "R9";
            M_HOT:  return "R5";
            M_OVL:  return "R3";
            default: return "R6";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state = M_OFF; m_lock = 1'b1; m_scale = '0;
        end else begin
            int ns;
            logic [SW-1:0] nsc;
            ns  = model_next(m_state, m_lock, m_scale);
            nsc = model_scale(m_state, m_scale);
            m_lock  = m_lock ? !vcc_start_ok : !vcc_hold_ok;
            m_state = ns;
            m_scale = nsc;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit eg, ef, ep;
            logic [SW-1:0] es;
            eg = (m_state == M_RUN) || (m_state == M_SOFT && m_scale != 0);
            ef = (m_state == M_OVL) || (m_state == M_OCR);
            ep = (m_state == M_RUN);
            es = (m_state == M_RUN) ? FULL : (m_state == M_SOFT ? m_scale : '0);
            check(gate_en_o == eg, {tag_of(m_state), " gate"}, gate_en_o, eg);
            check(force_low_o == ef, {tag_of(m_state), " force"}, force_low_o, ef);
            check(ss_scale_o == es, {tag_of(m_state), " scale"}, ss_scale_o, es);
            check(pgood_en_o == ep, {tag_of(m_state), " pgood"}, pgood_en_o, ep);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_run(input string tag);
        int k = 0;
        while (!pgood_en_o && k < 200) begin @(negedge clk); k++; end
        check(pgood_en_o == 1'b1, tag, pgood_en_o, 1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        cyc(3);
        // R1: reset state
        check(gate_en_o == 0 && force_low_o == 0 && ss_scale_o == 0 && pgood_en_o == 0,
              "R1 reset outputs", {gate_en_o, force_low_o, pgood_en_o}, 0);
        rst = 1'b0;
        cyc(1);
        check(gate_en_o == 0 && pgood_en_o == 0, "R1 after reset", gate_en_o, 0);
        tick_i = 1'b1;
        wait_run("R8 first start reaches run");
        check(ss_scale_o == FULL, "R8 full scale", ss_scale_o, FULL);

        // R2: hold-only band keeps the unlocked state
        vcc_start_ok = 1'b0;
        cyc(5);
        check(pgood_en_o == 1, "R2 band keeps running", pgood_en_o, 1);
        vcc_hold_ok = 1'b0; cyc(1); vcc_hold_ok = 1'b1;
        cyc(6);
        check(gate_en_o == 0, "R2 stays locked in band", gate_en_o, 0);
        vcc_start_ok = 1'b1;
        wait_run("R2 restart after release");

        // R4: overvoltage latch
        ov_i = 1'b1; cyc(1); ov_i = 1'b0;
        cyc(10);
        check(force_low_o == 1, "R4 latch holds", force_low_o, 1);
        en_i = 1'b0; hot_trip_i = 1'b1; oc_zero_i = 1'b1; cyc(4);
        en_i = 1'b1; hot_trip_i = 1'b0; oc_zero_i = 1'b0; cyc(4);
        check(force_low_o == 1 && gate_en_o == 0, "R4 other inputs ignored", force_low_o, 1);
        vcc_hold_ok = 1'b0; vcc_start_ok = 1'b0; cyc(3);
        check(force_low_o == 0, "R4 cleared by lockout", force_low_o, 0);
        vcc_hold_ok = 1'b1; vcc_start_ok = 1'b1;
        wait_run("R4 restart through soft-start");

        // R10: everything at once
        ov_i = 1'b1; vcc_hold_ok = 1'b0; vcc_start_ok = 1'b0;
        hot_trip_i = 1'b1; hot_clear_i = 1'b0; en_i = 1'b0; oc_trip_i = 1'b1;
        cyc(1);
        check(force_low_o == 1 && gate_en_o == 0, "R10 overvoltage wins", force_low_o, 1);
        ov_i = 1'b0; oc_trip_i = 1'b0; cyc(2);
        check(force_low_o == 0 && gate_en_o == 0, "R10 lockout next", force_low_o, 0);
        vcc_hold_ok = 1'b1; vcc_start_ok = 1'b1; cyc(4);
        check(gate_en_o == 0, "R5 thermal holds off", gate_en_o, 0);
        hot_trip_i = 1'b0; hot_clear_i = 1'b1; cyc(4);
        check(gate_en_o == 0, "R6 enable low holds off", gate_en_o, 0);
        en_i = 1'b1;
        wait_run("R5 restart after cooling");

        // R6: enable drop
        en_i = 1'b0; cyc(1);
        check(pgood_en_o == 0 && gate_en_o == 0, "R6 enable low", pgood_en_o, 0);
        en_i = 1'b1;
        wait_run("R6 re-enable");

        // R9: overcurrent recovery
        oc_trip_i = 1'b1; cyc(1); oc_trip_i = 1'b0;
        check(force_low_o == 1 && gate_en_o == 0, "R9 recovery", force_low_o, 1);
        cyc(3);
        oc_zero_i = 1'b1; tick_i = 1'b0; cyc(1); oc_zero_i = 1'b0;
        check(gate_en_o == 0 && ss_scale_o == 0, "R9 soft-start from zero", ss_scale_o, 0);

        // R7: zero step counts as one
        ss_step_i = '0; tick_i = 1'b1; cyc(3);
        check(ss_scale_o == 3, "R7 zero step", ss_scale_o, 3);
        ss_step_i = 8'd100;
        wait_run("R7 ramp completes");

        // random phase
        for (int i = 0; i < 20000; i++) begin
            ov_i        = ($urandom_range(0, 399) == 0);
            vcc_hold_ok = ($urandom_range(0, 299) != 0);
            vcc_start_ok = ($urandom_range(0, 3) != 0);
            hot_trip_i  = ($urandom_range(0, 299) == 0);
            hot_clear_i = ($urandom_range(0, 3) == 0);
            en_i        = ($urandom_range(0, 149) != 0);
            oc_trip_i   = ($urandom_range(0, 59) == 0);
            oc_zero_i   = ($urandom_range(0, 4) == 0);
            tick_i      = ($urandom_range(0, 1) == 0);
            ss_step_i   = SW'($urandom_range(0, 40));
            cyc(1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule